// File: doc/BRIEF.md
# Word and Doubleword Barrel Shifter with Extended Immediate Range

This block shifts a 64-bit operand left logically, right logically or right arithmetically. It works in one of two widths. A word shift acts on the low 32 bits of the operand and sign-extends the 32-bit result to 64 bits. A doubleword shift acts on all 64 bits. The shift count comes from one of two sources: a 5-bit immediate, or the low bits of a 64-bit count operand that an instruction reads from a register.

A 5-bit immediate cannot express a count above 31. For this reason the doubleword immediate forms have an extra select that adds 32 to the immediate, which covers counts from 32 to 63. The shift datapath itself is combinational. The result is captured in one output register so that the shifter fits an execute stage. Decoding, operand fetch and writeback are outside this block.

Top module: `shf_unit`

## Requirements
- R1: A left shift (right_i=0) fills the vacated low-order bit positions with zeros.
- R2: A logical right shift (right_i=1, arith_i=0) fills the vacated high-order positions with zeros. For a word shift this applies within the low 32 bits.
- R3: An arithmetic right shift (right_i=1, arith_i=1) fills the vacated positions with copies of the sign bit. The sign bit is operand bit 63 for a doubleword shift and operand bit 31 for a word shift.
- R4: For a doubleword shift with an immediate count (var_amt_i=0), plus32_i=1 makes the count imm_amt_i+32. plus32_i has no effect on word shifts or on variable-count shifts.
- R5: A variable-count word shift (var_amt_i=1, dword_i=0) uses only bits [4:0] of reg_amt_i as the count.
- R6: A variable-count doubleword shift (var_amt_i=1, dword_i=1) uses only bits [5:0] of reg_amt_i as the count.
- R7: A word shift ignores operand bits [63:32]. Its 32-bit result is sign-extended, so result bits [63:32] all equal result bit 31.
- R8: A count of zero returns the operand unchanged for a doubleword shift. For a word shift it returns the sign-extended low 32 bits of the operand.
- R9: arith_i has no effect when right_i=0.
- R10: result_o shows the shift of the inputs present at a rising clk_i edge, from that edge on. While rst_ni is low, result_o is zero, and it clears as soon as rst_ni falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the result register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| operand_i | input | 64 | Value to be shifted |
| imm_amt_i | input | 5 | Immediate shift count |
| reg_amt_i | input | 64 | Register-supplied shift count; only its low bits are used |
| var_amt_i | input | 1 | 1 selects reg_amt_i, 0 selects imm_amt_i |
| right_i | input | 1 | 1 shifts right, 0 shifts left |
| arith_i | input | 1 | 1 selects an arithmetic right shift |
| dword_i | input | 1 | 1 selects a doubleword shift, 0 a word shift |
| plus32_i | input | 1 | Adds 32 to the immediate count of a doubleword shift |
| result_o | output | 64 | Registered shift result |

## Verification
The assertions assume that every input is known and stable at each rising edge. They also assume that reset is applied before the first edge, because each property compares the registered result against the inputs sampled one edge earlier. The bench meets both assumptions. It changes inputs only on falling edges, draws every field from known random or directed values, and holds reset low for several cycles before releasing it. The random mix is weighted toward the immediate doubleword forms with plus32_i set, so the extended-count properties are exercised often.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic right;
    logic arith;
    logic dword;
  } shf_ctrl_t;
endpackage

// File: rtl/shf_amount.sv
module shf_amount #(
  parameter int unsigned DATA_W = shf_pkg::DATA_W,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-2:0]  imm_amt_i,
  input  logic [DATA_W-1:0] reg_amt_i,
  input  logic              var_amt_i,
  input  logic              dword_i,
  input  logic              plus32_i,
  output logic [AMT_W-1:0]  amt_o
);
  logic [AMT_W-1:0] reg_cnt;

  // word forms drop the top count bit
  assign reg_cnt = dword_i ? reg_amt_i[AMT_W-1:0] : {1'b0, reg_amt_i[AMT_W-2:0]};

  always_comb begin
    if (var_amt_i) amt_o = reg_cnt;
    else           amt_o = {dword_i & plus32_i, imm_amt_i};
  end
endmodule

// File: rtl/shf_prep.sv
module shf_prep #(
  parameter int unsigned DATA_W = shf_pkg::DATA_W,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] operand_i,
  input  shf_pkg::shf_ctrl_t ctrl_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fill_o
);
  logic sign;

  assign sign   = ctrl_i.dword ? operand_i[DATA_W-1] : operand_i[HALF_W-1];
  assign fill_o = ctrl_i.right & ctrl_i.arith & sign;
  // word: upper half pre-loaded with fill so right shifts pull it in
  assign data_o = ctrl_i.dword ? operand_i : {{HALF_W{fill_o}}, operand_i[HALF_W-1:0]};
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int unsigned DATA_W = shf_pkg::DATA_W,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              fill_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = left_i ? data_i[DATA_W-1-i] : data_i[i];
    assign rev_out[i] = left_i ? stage[AMT_W][DATA_W-1-i] : stage[AMT_W][i];
  end

  assign stage[0] = rev_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{SH{fill_i}}, stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign data_o = rev_out;
endmodule

// File: rtl/shf_fmt.sv
module shf_fmt #(
  parameter int unsigned DATA_W = shf_pkg::DATA_W,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              dword_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = dword_i ? data_i : {{HALF_W{data_i[HALF_W-1]}}, data_i[HALF_W-1:0]};
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int unsigned DATA_W = shf_pkg::DATA_W,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-2:0]  imm_amt_i,
  input  logic [DATA_W-1:0] reg_amt_i,
  input  logic              var_amt_i,
  input  logic              right_i,
  input  logic              arith_i,
  input  logic              dword_i,
  input  logic              plus32_i,
  output logic [DATA_W-1:0] result_o
);
  shf_pkg::shf_ctrl_t ctrl;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] prep_data;
  logic              fill;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;

  assign ctrl.right = right_i;
  assign ctrl.arith = arith_i;
  assign ctrl.dword = dword_i;

  shf_amount #(.DATA_W(DATA_W)) i_amount (
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .var_amt_i (var_amt_i),
    .dword_i   (dword_i),
    .plus32_i  (plus32_i),
    .amt_o     (amt)
  );

  shf_prep #(.DATA_W(DATA_W)) i_prep (
    .operand_i (operand_i),
    .ctrl_i    (ctrl),
    .data_o    (prep_data),
    .fill_o    (fill)
  );

  shf_barrel #(.DATA_W(DATA_W)) i_barrel (
    .data_i (prep_data),
    .amt_i  (amt),
    .fill_i (fill),
    .left_i (~right_i),
    .data_o (shifted)
  );

  shf_fmt #(.DATA_W(DATA_W)) i_fmt (
    .data_i  (shifted),
    .dword_i (dword_i),
    .data_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign result_o = res_q;
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] operand_i,
  input logic [AMT_W-2:0]  imm_amt_i,
  input logic              var_amt_i,
  input logic              right_i,
  input logic              arith_i,
  input logic              dword_i,
  input logic              plus32_i,
  input logic [DATA_W-1:0] result_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_left_zero_fill_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!right_i && dword_i && !var_amt_i && (plus32_i || imm_amt_i != '0))
      |-> result_o[0] == 1'b0);

  assert_plus32_logic_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(right_i && !arith_i && dword_i && !var_amt_i && plus32_i)
      |-> result_o[DATA_W-1:HALF_W] == '0);

  assert_plus32_sign_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(right_i && arith_i && dword_i && !var_amt_i && plus32_i)
      |-> result_o[DATA_W-1:HALF_W] == {HALF_W{$past(operand_i[DATA_W-1])}});

  assert_word_sext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!dword_i)
      |-> result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}});

  assert_zero_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(dword_i && !var_amt_i && !plus32_i && imm_amt_i == '0)
      |-> result_o == $past(operand_i));
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W)) i_shf_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .operand_i (operand_i),
  .imm_amt_i (imm_amt_i),
  .var_amt_i (var_amt_i),
  .right_i   (right_i),
  .arith_i   (arith_i),
  .dword_i   (dword_i),
  .plus32_i  (plus32_i),
  .result_o  (result_o)
);

// File: tb/test_shf_unit.sv
`timescale 1ns/1ps
module test_shf_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] operand_i = '0;
  logic [4:0]  imm_amt_i = '0;
  logic [63:0] reg_amt_i = '0;
  logic        var_amt_i = 1'b0;
  logic        right_i = 1'b0;
  logic        arith_i = 1'b0;
  logic        dword_i = 1'b0;
  logic        plus32_i = 1'b0;
  logic [63:0] result_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  shf_unit i_shf_unit (
    .clk_i, .rst_ni, .operand_i, .imm_amt_i, .reg_amt_i, .var_amt_i,
    .right_i, .arith_i, .dword_i, .plus32_i, .result_o
  );

  function automatic logic [63:0] model(logic [63:0] op, logic [4:0] imm, logic [63:0] ra,
                                        bit v, bit r, bit a, bit dw, bit p32);
    int n;
    logic [31:0] w;
    logic [63:0] d;
    if (dw) n = v ? int'(ra % 64) : int'(imm) + (p32 ? 32 : 0);
    else    n = v ? int'(ra % 32) : int'(imm);
    if (dw) begin
      if (!r)     d = op << n;
      else if (a) d = $signed(op) >>> n;
      else        d = op >> n;
      return d;
    end
    w = op[31:0];
    if (!r)     w = w << n;
    else if (a) w = $signed(w) >>> n;
    else        w = w >> n;
    return {{32{w[31]}}, w};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [63:0] op, logic [4:0] imm, logic [63:0] ra,
                     bit v, bit r, bit a, bit dw, bit p32);
    @(negedge clk_i);
    operand_i = op; imm_amt_i = imm; reg_amt_i = ra; var_amt_i = v;
    right_i = r; arith_i = a; dword_i = dw; plus32_i = p32;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, result_o, model(op, imm, ra, v, r, a, dw, p32));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("TIMEOUT: watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state with busy inputs
    operand_i = 64'hDEAD_BEEF_0123_4567; imm_amt_i = 5'd3; dword_i = 1'b1;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check("R10 reset", result_o, '0);
    rst_ni = 1'b1;

    // R8 zero count
    run("R8 dword zero", 64'hF00D_CAFE_8765_4321, 5'd0, '0, 0, 1, 1, 1, 0);
    run("R8 word zero", 64'h1234_5678_8000_0001, 5'd0, '0, 0, 0, 0, 0, 0);
    // R1 left zero fill
    run("R1 dword left", 64'hFFFF_FFFF_FFFF_FFFF, 5'd4, '0, 0, 0, 0, 1, 0);
    run("R1 word left 31", 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, '0, 0, 0, 0, 0, 0);
    // R2 logical right, count 63 via +32
    run("R2 dword right 63", 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, '0, 0, 1, 0, 1, 1);
    run("R2 word right", 64'hFFFF_FFFF_F000_0000, 5'd4, '0, 0, 1, 0, 0, 0);
    // R3 arithmetic right
    run("R3 dword arith 32", 64'h8000_0000_1234_5678, 5'd0, '0, 0, 1, 1, 1, 1);
    run("R3 word arith bit31", 64'h0000_0000_8000_0010, 5'd4, '0, 0, 1, 1, 0, 0);
    run("R3 word arith pos", 64'hFFFF_FFFF_7000_0000, 5'd8, '0, 0, 1, 1, 0, 0);
    // R4 plus32
    run("R4 dword left +32", 64'h0000_0000_0000_00A5, 5'd3, '0, 0, 0, 0, 1, 1);
    run("R4 word ignores +32", 64'h0000_0000_0000_00A5, 5'd3, '0, 0, 0, 0, 0, 1);
    run("R4 var ignores +32", 64'h0000_0000_0000_00A5, 5'd31, 64'd2, 1, 0, 0, 1, 1);
    // R5 / R6 count masking
    run("R5 var word low5", 64'h0000_0000_8000_0000, 5'd7, 64'hFFFF_FFFF_FFFF_FFE1, 1, 1, 1, 0, 0);
    run("R6 var dword low6", 64'h8000_0000_0000_0000, 5'd0, 64'h0000_0000_0000_01C7, 1, 1, 0, 1, 0);
    run("R6 var dword 63", 64'h0000_0000_0000_0001, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 1, 0);
    // R7 upper bits ignored in word mode
    run("R7 word upper ignored", 64'hABCD_EF01_0000_4000, 5'd17, '0, 0, 0, 0, 0, 0);
    // R9 arith on left shift
    run("R9 left arith dword", 64'h8000_0000_0000_0003, 5'd5, '0, 0, 0, 1, 1, 1);
    run("R9 left arith word", 64'h0000_0000_8000_0003, 5'd2, '0, 0, 0, 1, 0, 0);

    // mixed random traffic, weighted toward +32 immediates
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      logic [63:0] ra;
      logic [4:0]  im;
      bit v, r, a, dw, p;
      op = {$urandom(), $urandom()};
      ra = {$urandom(), $urandom()};
      im = 5'($urandom());
      v = ($urandom() % 3) == 0;
      r = 1'($urandom()); a = 1'($urandom());
      dw = ($urandom() % 4) != 0; p = ($urandom() % 3) != 0;
      run("R1 R2 R3 R4 R5 R6 R7 random", op, im, ra, v, r, a, dw, p);
    end

    // R10 async clear between edges
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check("R10 async clear", result_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run("R10 after release", 64'h0000_0000_0000_0001, 5'd9, '0, 0, 0, 0, 1, 0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule